// File: doc/BRIEF.md
# Conversion Period Sync Aligner

This block produces the sample timing for a sampling converter. A phase counter runs off the master clock and closes a conversion interval every programmed number of cycles. At the close of each interval it pulses an active-low data-ready output for one cycle. The interval length comes from a 16-bit configuration input. The block takes that value only when data-ready fires, and also while reset is held.

Several converters share one active-low sync line so that their sample instants line up. The sync input passes through a two-flop synchronizer before edge detection. When the block sees a synchronized falling edge, it records how many master cycles have passed since its own last data-ready cycle. The conversion under way is not shortened, and the next data-ready arrives on schedule. From that data-ready cycle the block holds the converter idle for the recorded number of cycles. During that hold, pause-active is high and conversion-enable is low. The data-ready after the hold is therefore late by exactly the recorded amount, and later intervals run at the normal length again. Every device delays its own phase by its own recorded offset, so after one realignment all devices share the phase of the common sync edge.

Top module: `sync_aligner`

## Requirements
- R1: While rstN is low, drdyN is 1, pauseActive is 0 and convEn is 1. After rstN is released, the first data-ready low cycle follows the P-th rising clock edge at which rstN is high, where P is the configured period. drdyN is low for exactly one cycle per event.
- R2: The period is sampled from periodCfg while in reset and at every data-ready event. A new value first governs the interval that begins at the next event. Values 0 and 1 act as 2.
- R3: Only a falling edge of syncN starts a realignment. A rising edge changes no later data-ready timing.
- R4: If syncN is driven low (and held) in the j-th cycle after a data-ready cycle, where the data-ready cycle is j = 0, the recorded offset is j + 2. This accounts for the two-flop synchronizer.
- R5: The first data-ready after the sync edge still arrives one normal period after the previous one.
- R6: Starting in that data-ready cycle, pauseActive is high for exactly offset cycles, and convEn is the inverse of pauseActive in every cycle.
- R7: The data-ready after the pause comes period + offset cycles after the one before it. Later events are spaced by the normal period again.
- R8: A second falling edge that arrives while a realignment is still pending replaces the recorded offset. Only one pause is inserted.
- R9: A falling edge detected in a data-ready cycle records offset 0. That realignment inserts no idle cycles and leaves all spacing at the normal period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous reset, active low |
| periodCfg | input | 16 | Sample period in master clock cycles |
| syncN | input | 1 | Asynchronous sync request, active low, falling edge acts |
| drdyN | output | 1 | Data-ready, low for one cycle per sample |
| pauseActive | output | 1 | High during inserted idle cycles |
| convEn | output | 1 | Conversion enable, low during inserted idle cycles |

## Verification
Some properties can be checked on every cycle. These are: the one-cycle width of each data-ready pulse, the rule that a pause can only begin in a data-ready cycle, the absence of any data-ready inside a running pause, and the idle state of the outputs coming out of reset. The exact cycle counts need driven scenarios to show. These include the gap spacing before and after a realignment, the j + 2 offset through the synchronizer, the timing of period reloads, replacement of a pending offset, and the zero-offset case. The bench shows them by measuring gaps between data-ready events against values worked out from the requirements.

// File: rtl/sync_aligner_pkg.sv
package sync_aligner_pkg;
  typedef struct packed {
    logic fire;       // close the interval, pulse data-ready
    logic capture;    // record the offset since the last data-ready
    logic loadPause;  // start the hold-off with the recorded offset
  } ctlStrobes_t;

  typedef struct packed {
    logic periodDone; // interval reached its last cycle, not paused
    logic syncFall;   // synchronized falling edge of the sync line
  } dpStatus_t;
endpackage

// File: rtl/sync_aligner_dp.sv
module sync_aligner_dp
  import sync_aligner_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic             syncN,
  input  ctlStrobes_t      ctl,
  output dpStatus_t        status,
  output logic             pauseBusy
);
  localparam logic [CNT_W-1:0] MIN_PERIOD = CNT_W'(2);
  localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};

  logic [SYNC_STAGES:0] syncPipe;
  logic [CNT_W-1:0]     curPeriod;
  logic [CNT_W-1:0]     phaseCnt;
  logic [CNT_W-1:0]     sinceDrdy;
  logic [CNT_W-1:0]     offsetReg;
  logic [CNT_W-1:0]     pauseCnt;
  logic [CNT_W-1:0]     cfgClamped;

  assign cfgClamped = (periodCfg < MIN_PERIOD) ? MIN_PERIOD : periodCfg;

  // synchronizer stages plus one history bit for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) syncPipe <= '1;
    else       syncPipe <= {syncPipe[SYNC_STAGES-1:0], syncN};
  end

  assign status.syncFall = syncPipe[SYNC_STAGES] & ~syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN)         curPeriod <= cfgClamped;
    else if (ctl.fire) curPeriod <= cfgClamped;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           phaseCnt <= '0;
    else if (ctl.fire)   phaseCnt <= '0;
    else if (!pauseBusy) phaseCnt <= phaseCnt + 1'b1;
  end

  assign status.periodDone = !pauseBusy && (phaseCnt == curPeriod - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN)                   sinceDrdy <= '0;
    else if (ctl.fire)           sinceDrdy <= '0;
    else if (sinceDrdy != CNT_MAX) sinceDrdy <= sinceDrdy + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            offsetReg <= '0;
    else if (ctl.capture) offsetReg <= sinceDrdy;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              pauseCnt <= '0;
    else if (ctl.loadPause) pauseCnt <= offsetReg;
    else if (pauseBusy)     pauseCnt <= pauseCnt - 1'b1;
  end

  assign pauseBusy = (pauseCnt != '0);
endmodule

// File: rtl/sync_aligner_ctrl.sv
module sync_aligner_ctrl
  import sync_aligner_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctlStrobes_t ctl,
  output logic        drdyN
);
  logic pending;

  assign ctl.fire      = status.periodDone;
  assign ctl.capture   = status.syncFall;
  assign ctl.loadPause = status.periodDone && pending;

  // a new edge always wins over consumption in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)                  pending <= 1'b0;
    else if (status.syncFall)   pending <= 1'b1;
    else if (status.periodDone) pending <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) drdyN <= 1'b1;
    else       drdyN <= ~status.periodDone;
  end
endmodule

// File: rtl/sync_aligner.sv
module sync_aligner
  import sync_aligner_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic             syncN,
  output logic             drdyN,
  output logic             pauseActive,
  output logic             convEn
);
  ctlStrobes_t ctl;
  dpStatus_t   status;
  logic        pauseBusy;

  sync_aligner_dp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .periodCfg(periodCfg), .syncN(syncN),
    .ctl(ctl), .status(status), .pauseBusy(pauseBusy)
  );

  sync_aligner_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .status(status), .ctl(ctl), .drdyN(drdyN)
  );

  assign pauseActive = pauseBusy;
  assign convEn      = ~pauseBusy;
endmodule

// File: rtl/sync_aligner_chk.sv
module sync_aligner_chk (
  input logic clk,
  input logic rstN,
  input logic drdyN,
  input logic pauseActive
);
  // R1: data-ready is a single-cycle pulse
  p_drdy_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    !drdyN |=> drdyN);

  // R1: reset drives the idle output state
  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (drdyN && !pauseActive));

  // R6: a hold-off can only begin in a data-ready cycle
  p_pause_starts_at_drdy_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pauseActive) |-> !drdyN);

  // R7: no data-ready is issued inside a running hold-off
  p_no_drdy_in_pause_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pauseActive && $past(pauseActive)) |-> drdyN);
endmodule

bind sync_aligner sync_aligner_chk u_chk (
  .clk(clk), .rstN(rstN), .drdyN(drdyN), .pauseActive(pauseActive)
);

// File: tb/sim_sync_aligner.sv
module sim_sync_aligner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] periodCfg = 16'd8;
  logic        syncN = 1'b1;
  logic        drdyN, pauseActive, convEn;

  int checks = 0;
  int errors = 0;
  int convErr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_aligner u0 (
    .clk(clk), .rstN(rstN), .periodCfg(periodCfg), .syncN(syncN),
    .drdyN(drdyN), .pauseActive(pauseActive), .convEn(convEn)
  );

  // period, sync delay j, expected post-pause gap (period + j + 2)
  localparam int VEC_N = 4;
  localparam int vecTab [VEC_N][3] = '{
    '{8, 0, 10}, '{12, 3, 17}, '{20, 10, 32}, '{5, 1, 8}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset(input int p);
    rstN = 1'b0; syncN = 1'b1; periodCfg = 16'(p);
    repeat (3) @(negedge clk);
    check("R1 reset drdyN", int'(drdyN), 1);
    check("R1 reset pauseActive", int'(pauseActive), 0);
    check("R1 reset convEn", int'(convEn), 1);
    rstN = 1'b1;
  endtask

  // counts negedges until a data-ready low cycle; tallies pause cycles
  task automatic measure(output int gap, output int pcnt);
    gap = 0; pcnt = 0;
    do begin
      @(negedge clk);
      gap++;
      if (pauseActive) pcnt++;
      if (convEn === pauseActive) convErr++;
    end while (drdyN && gap < 2000);
  endtask

  task automatic waitN(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    int g0, g1, g2, g3, p0, p1, p2, p3;
    for (int v = 0; v < VEC_N; v++) begin
      doReset(vecTab[v][0]);
      measure(g0, p0);
      check("R1 first drdy after reset", g0, vecTab[v][0]);
      waitN(vecTab[v][1]);
      syncN = 1'b0;
      measure(g1, p1);
      g1 += vecTab[v][1];
      check("R5 gap after sync edge", g1, vecTab[v][0]);
      syncN = 1'b1;                          // R3 rising edge, no effect
      measure(g2, p2);
      check("R7 delayed gap", g2, vecTab[v][2]);
      check("R6 pause length / R4 offset", p1 + p2, vecTab[v][1] + 2);
      measure(g3, p3);
      check("R7 R3 normal gap after pause", g3, vecTab[v][0]);
      check("R6 no extra pause", p3, 0);
    end

    // R2: reload only at data-ready
    doReset(10);
    measure(g0, p0);
    periodCfg = 16'd6;
    measure(g1, p1);
    check("R2 old period holds in current interval", g1, 10);
    measure(g2, p2);
    check("R2 new period after reload", g2, 6);

    // R2: values below two act as two
    doReset(1);
    measure(g0, p0);
    check("R2 clamp period 1", g0, 2);
    periodCfg = 16'd0;
    measure(g1, p1);
    measure(g2, p2);
    check("R2 clamp period 0", g2, 2);

    // R8: second edge replaces pending offset (2 -> 7)
    doReset(16);
    measure(g0, p0);
    syncN = 1'b0;
    waitN(2);
    syncN = 1'b1;
    waitN(3);
    syncN = 1'b0;
    measure(g1, p1);
    g1 += 5;
    check("R8 gap before pause", g1, 16);
    syncN = 1'b1;
    measure(g2, p2);
    check("R8 replaced offset gap", g2, 23);
    check("R8 single pause length", p1 + p2, 7);
    measure(g3, p3);
    check("R8 no stacked pause", g3, 16);

    // R9: edge detected in the data-ready cycle gives offset 0
    doReset(10);
    measure(g0, p0);
    waitN(8);
    syncN = 1'b0;
    measure(g1, p1);
    g1 += 8;
    check("R9 gap with edge at drdy", g1, 10);
    syncN = 1'b1;
    measure(g2, p2);
    check("R9 zero offset gap", g2, 10);
    measure(g3, p3);
    check("R9 zero offset later gap", g3, 10);
    check("R9 no pause cycles", p1 + p2 + p3, 0);

    check("R6 convEn inverse of pauseActive", convErr, 0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule